// File: doc/BRIEF.md
# Four-Level Page Table Walker with 64-bit Entries

This block turns a virtual address into a physical address by reading 64-bit translation entries from memory. It walks four table levels when long mode is active and three levels otherwise (the legacy 64-bit-entry layout). A caller supplies the address, the kind of access, the privilege of the requester and the paging controls, then pulses `start`. The walker issues one memory transaction at a time and checks each entry it fetches. Where an entry's accessed flag is clear, or a write reaches a clean final entry, it writes the entry back with those flags set. When the walk ends it reports either the physical address with the rights a translation cache may grant, or a page-fault error code. A non-canonical address in long mode is reported as a general-protection fault.

The result stays on the outputs until the caller acknowledges it. Only then does the walker accept another request. Translation caching is left to the surrounding logic.

Top module: `pae_walker`

## Requirements
- R1: With `lma`=1, a virtual address whose bits 63:47 are not all equal ends the walk with `gpf`=1, `fault`=0 and `err_code`=0. No memory transaction is issued.
- R2: In long mode the walker reads four levels. The entry for each level is at the table base (CR3 with bits 11:0 cleared, or the previous entry's bits PA_W-1:12) plus 8 times a 9-bit index. The indices are VA[47:39], VA[38:30], VA[29:21] and VA[20:12], in that order.
- R3: With `lma`=0 the walk has three levels. The first entry is at CR3 with bits 4:0 cleared plus VA[31:30]*8. That entry only needs bit 0 set: it grants full user, write and execute rights, is never checked for bit 63, and is never written back.
- R4: An entry with bit 0 (present) clear ends the walk with `fault`=1 and `err_code` bit 0 clear.
- R5: An entry with bit 63 (no-execute) set while `nxe`=0 faults with `err_code` bits 3 and 0 set.
- R6: User, write and execute rights are the AND over all levels of bit 2, bit 1 and the inverted bit 63. `acc` is 0 for read, 1 for write and 2 for fetch. A fault occurs for a fetch without execute right, a user access without user right, or a write without write right when `user`=1 or `wp`=1.
- R7: `err_code` bit 1 is set for a write, bit 2 for a user access, and bit 4 for a fetch when `nxe`=1. Bit 0 is set for protection and reserved faults.
- R8: Every non-final entry visited with bit 5 (accessed) clear is rewritten with bit 5 set. A successful final entry is rewritten with bit 5 set, and also bit 6 (dirty) on a write, only when that changes it. A faulting final entry is not written.
- R9: A third-level entry with bit 7 set ends the walk as a 2 MiB page. The physical address is entry bits PA_W-1:21 joined with VA[20:0].
- R10: On success `perm_u` and `perm_x` give the combined user and execute rights. `perm_w` is 1 only if the final entry is dirty after the walk and either the write right holds or the access is supervisor with `wp`=0.
- R11: Table addresses and the physical page base are ANDed with `a20_mask`. Entry bits 62:PA_W are ignored.
- R12: `busy` is high during a walk. `done` and all result outputs hold until `res_ack`. `mem_req`, `mem_we` and `mem_addr` hold until `mem_ack`.
- R13: After reset `busy`, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (taken when idle) |
| va | input | 64 | Virtual address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| user | input | 1 | Requester is user mode |
| cr3 | input | PA_W | Top table base |
| wp | input | 1 | Supervisor write protection enable |
| nxe | input | 1 | No-execute enable |
| lma | input | 1 | Long mode active (four levels) |
| a20_mask | input | PA_W | Mask ANDed onto physical addresses |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid |
| fault | output | 1 | Page fault |
| gpf | output | 1 | General-protection fault (non-canonical) |
| err_code | output | 5 | Page-fault error code |
| pa | output | PA_W | Translated physical address |
| perm_w | output | 1 | Write may be cached as allowed |
| perm_x | output | 1 | Execute allowed |
| perm_u | output | 1 | User access allowed |
| res_ack | input | 1 | Result consumed |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | PA_W | Entry address |
| mem_wdata | output | 64 | Write-back entry value |
| mem_rdata | input | 64 | Read entry value |
| mem_ack | input | 1 | Transaction complete |

## Verification
A wrong level counter or table base shows up as a wrong `mem_addr` on the very next read. Because the bench memory returns zero for unmapped addresses, the walk then ends in a not-present fault instead of a translation. A corrupted rights accumulator or fault condition changes `fault`, `err_code` or `perm_w` when that walk completes, and the fault sweep covers every combination of final-entry flags. A missing or extra write-back is seen in the entry's value in memory right after the walk is acknowledged.

// File: rtl/pw_pkg.sv
package pw_pkg;
   typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;

   // entry flag positions
   localparam int unsigned F_PRES  = 0;
   localparam int unsigned F_RW    = 1;
   localparam int unsigned F_US    = 2;
   localparam int unsigned F_ACC   = 5;
   localparam int unsigned F_DIRTY = 6;
   localparam int unsigned F_BIG   = 7;
   localparam int unsigned F_NOX   = 63;

   // error code positions
   localparam int unsigned E_PROT  = 0;
   localparam int unsigned E_WR    = 1;
   localparam int unsigned E_USR   = 2;
   localparam int unsigned E_RSV   = 3;
   localparam int unsigned E_INST  = 4;

   typedef struct packed {
      logic x;
      logic u;
      logic w;
   } rights_t;
endpackage

// File: rtl/pw_index.sv
module pw_index #(
   parameter int PA_W   = 40,
   parameter int LEVELS = 4
) (
   input  logic [35:0]                 vpn,
   input  logic [PA_W-1:0]             base,
   input  logic [$clog2(LEVELS)-1:0]   lvl,
   input  logic                        legacy_top,
   input  logic [PA_W-1:0]             a20,
   output logic [PA_W-1:0]             addr
);
   logic [8:0] idx [LEVELS];
   logic [8:0] sel;

   for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx[g] = vpn[9*g +: 9];
   end

   always_comb begin
      sel  = legacy_top ? {7'd0, vpn[19:18]} : idx[lvl];
      addr = (base + {{(PA_W-12){1'b0}}, sel, 3'b000}) & a20;
   end
endmodule

// File: rtl/pw_rights.sv
module pw_rights
   import pw_pkg::*;
(
   input  rights_t rt,
   input  logic    is_write,
   input  logic    is_fetch,
   input  logic    user,
   input  logic    wp,
   input  logic    dirty_after,
   output logic    prot_fault,
   output logic    perm_w
);
   always_comb begin
      prot_fault = (is_fetch && !rt.x) || (user && !rt.u) ||
                   (is_write && !rt.w && (user || wp));
      perm_w     = dirty_after && (rt.w || (!user && !wp));
   end
endmodule

// File: rtl/pae_walker.sv
module pae_walker
   import pw_pkg::*;
#(
   parameter int PA_W = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [63:0]     va,
   input  logic [1:0]      acc,
   input  logic            user,
   input  logic [PA_W-1:0] cr3,
   input  logic            wp,
   input  logic            nxe,
   input  logic            lma,
   input  logic [PA_W-1:0] a20_mask,
   output logic            busy,
   output logic            done,
   output logic            fault,
   output logic            gpf,
   output logic [4:0]      err_code,
   output logic [PA_W-1:0] pa,
   output logic            perm_w,
   output logic            perm_x,
   output logic            perm_u,
   input  logic            res_ack,
   output logic            mem_req,
   output logic            mem_we,
   output logic [PA_W-1:0] mem_addr,
   output logic [63:0]     mem_wdata,
   input  logic [63:0]     mem_rdata,
   input  logic            mem_ack
);
   localparam int LEVELS = 4;
   localparam int LW     = $clog2(LEVELS);
   localparam logic [63:0] ENT_KEEP = (64'd1 << 63) | ((64'd1 << PA_W) - 64'd1);

   if (PA_W < 32 || PA_W > 52) begin : g_bad_pa_w
      $error("pae_walker: PA_W out of range");
   end

   typedef enum logic [2:0] {S_IDLE, S_READ, S_CHECK, S_WBACK, S_DONE} st_e;
   st_e             st;
   logic [47:0]     va_q;
   logic            wr_q, fe_q, user_q, wp_q, nxe_q, leaf_q, top_q;
   logic [PA_W-1:0] a20_q, base_q, eaddr_q, ent_addr;
   logic [LW-1:0]   lvl_q;
   logic [63:0]     ent_q, wdata_q;
   rights_t         rt_q, rt_new;
   logic            canon, leaf, nx_bad, prot_f, pw_new, need_wb;
   logic [4:0]      code_base;
   logic [PA_W-1:0] pa_new;

   pw_index #(.PA_W(PA_W), .LEVELS(LEVELS)) u_index (
      .vpn(va_q[47:12]), .base(base_q), .lvl(lvl_q),
      .legacy_top(top_q), .a20(a20_q), .addr(ent_addr));

   pw_rights u_rights (
      .rt(rt_new), .is_write(wr_q), .is_fetch(fe_q), .user(user_q), .wp(wp_q),
      .dirty_after(ent_q[F_DIRTY] | wr_q), .prot_fault(prot_f), .perm_w(pw_new));

   always_comb begin
      canon  = (&va[63:47]) || !(|va[63:47]);
      rt_new = top_q ? rt_q : '{x: rt_q.x & ~ent_q[F_NOX],
                                 u: rt_q.u & ent_q[F_US],
                                 w: rt_q.w & ent_q[F_RW]};
      leaf   = (lvl_q == LW'(0)) || (lvl_q == LW'(1) && ent_q[F_BIG]);
      nx_bad = ent_q[F_NOX] && !nxe_q && !top_q;
      code_base           = '0;
      code_base[E_WR]     = wr_q;
      code_base[E_USR]    = user_q;
      code_base[E_INST]   = fe_q && nxe_q;
      need_wb = !ent_q[F_ACC] || (wr_q && !ent_q[F_DIRTY]);
      if (lvl_q == LW'(1))
         pa_new = ({ent_q[PA_W-1:21], 21'd0} & a20_q) | {{(PA_W-21){1'b0}}, va_q[20:0]};
      else
         pa_new = ({ent_q[PA_W-1:12], 12'd0} & a20_q) | {{(PA_W-12){1'b0}}, va_q[11:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  va_q <= '0;  wr_q <= 1'b0;  fe_q <= 1'b0;
         user_q <= 1'b0;  wp_q <= 1'b0;  nxe_q <= 1'b0;  leaf_q <= 1'b0;
         top_q <= 1'b0;  a20_q <= '0;  base_q <= '0;  eaddr_q <= '0;
         lvl_q <= '0;  ent_q <= '0;  wdata_q <= '0;  rt_q <= '0;
         fault <= 1'b0;  gpf <= 1'b0;  err_code <= '0;  pa <= '0;
         perm_w <= 1'b0;  perm_x <= 1'b0;  perm_u <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               va_q   <= va[47:0];
               wr_q   <= (acc == ACC_WRITE);
               fe_q   <= (acc == ACC_FETCH);
               user_q <= user;  wp_q <= wp;  nxe_q <= nxe;  a20_q <= a20_mask;
               fault <= 1'b0;  gpf <= 1'b0;  err_code <= '0;  pa <= '0;
               perm_w <= 1'b0;  perm_x <= 1'b0;  perm_u <= 1'b0;
               leaf_q <= 1'b0;  rt_q <= '1;
               if (lma && !canon) begin
                  gpf <= 1'b1;
                  st  <= S_DONE;
               end else begin
                  base_q <= lma ? {cr3[PA_W-1:12], 12'd0} : {cr3[PA_W-1:5], 5'd0};
                  lvl_q  <= lma ? LW'(3) : LW'(2);
                  top_q  <= !lma;
                  st     <= S_READ;
               end
            end
            S_READ: if (mem_ack) begin
               eaddr_q <= ent_addr;
               ent_q   <= mem_rdata & ENT_KEEP;
               st      <= S_CHECK;
            end
            S_CHECK: begin
               if (!ent_q[F_PRES]) begin
                  fault <= 1'b1;  err_code <= code_base;  st <= S_DONE;
               end else if (nx_bad) begin
                  fault    <= 1'b1;
                  err_code <= code_base | 5'(1 << E_PROT) | 5'(1 << E_RSV);
                  st       <= S_DONE;
               end else if (!leaf) begin
                  rt_q   <= rt_new;
                  base_q <= {ent_q[PA_W-1:12], 12'd0};
                  lvl_q  <= lvl_q - LW'(1);
                  top_q  <= 1'b0;
                  if (!ent_q[F_ACC] && !top_q) begin
                     wdata_q <= ent_q | (64'd1 << F_ACC);
                     st      <= S_WBACK;
                  end else begin
                     st <= S_READ;
                  end
               end else if (prot_f) begin
                  fault <= 1'b1;  err_code <= code_base | 5'(1 << E_PROT);  st <= S_DONE;
               end else begin
                  pa     <= pa_new;
                  perm_w <= pw_new;  perm_x <= rt_new.x;  perm_u <= rt_new.u;
                  leaf_q <= 1'b1;
                  wdata_q <= ent_q | (64'd1 << F_ACC) | (wr_q ? (64'd1 << F_DIRTY) : 64'd0);
                  st     <= need_wb ? S_WBACK : S_DONE;
               end
            end
            S_WBACK: if (mem_ack) st <= leaf_q ? S_DONE : S_READ;
            S_DONE:  if (res_ack) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (st == S_READ) || (st == S_CHECK) || (st == S_WBACK);
      done      = (st == S_DONE);
      mem_req   = (st == S_READ) || (st == S_WBACK);
      mem_we    = (st == S_WBACK);
      mem_addr  = (st == S_WBACK) ? eaddr_q : ent_addr;
      mem_wdata = wdata_q;
   end
endmodule

// File: rtl/pae_walker_chk.sv
module pae_walker_chk #(
   parameter int PA_W = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [63:0]     va,
   input logic            lma,
   input logic            busy,
   input logic            done,
   input logic            fault,
   input logic            gpf,
   input logic [4:0]      err_code,
   input logic [PA_W-1:0] pa,
   input logic            res_ack,
   input logic            mem_req,
   input logic            mem_we,
   input logic [PA_W-1:0] mem_addr,
   input logic [63:0]     mem_wdata,
   input logic            mem_ack
);
   p_noncanon_gpf_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !done && lma && !((&va[63:47]) || !(|va[63:47]))
      |=> done && gpf && !mem_req);

   p_fault_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(fault && gpf));

   p_rsvd_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault && err_code[3] |-> err_code[0]);

   p_wback_accessed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[5]);

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done && !res_ack |=> done && $stable(pa) && $stable(err_code) && $stable(fault));

   p_busy_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);
endmodule

bind pae_walker pae_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/tb_pae_walker.sv
module tb_pae_walker;
   localparam int PA_W = 40;
   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, user = 0, wp = 0, nxe = 0, lma = 1, res_ack = 0;
   logic [63:0] va = '0;
   logic [1:0]  acc = '0;
   logic [PA_W-1:0] cr3 = 40'h1000, a20_mask = '1;
   logic busy, done, fault, gpf, perm_w, perm_x, perm_u, mem_req, mem_we;
   logic [4:0] err_code;
   logic [PA_W-1:0] pa, mem_addr;
   logic [63:0] mem_wdata, mem_rdata = '0;
   logic mem_ack = 1'b0;

   int n_tests = 0, n_fail = 0, n_req = 0, cyc = 0;
   logic [63:0] mem [logic [PA_W-1:0]];
   logic r_fault, r_gpf, r_pw, r_px, r_pu;
   logic [4:0] r_err;
   logic [PA_W-1:0] r_pa;

   localparam logic [63:0] VA_L = 64'h0000_0080_8060_4abc;
   localparam logic [63:0] PG   = 64'h0000_0000_1234_5000;

   always #2 clk = ~clk;

   pae_walker #(.PA_W(PA_W)) dut (.*);

   always @(negedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         n_req = n_req + 1;
         if (mem_we) mem[mem_addr] = mem_wdata;
         else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
      end
   end

   function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic walk(input logic [63:0] v, input logic [1:0] a, input logic u,
                       input int hold);
      int n;
      @(negedge clk); va = v; acc = a; user = u; start = 1'b1;
      @(negedge clk); start = 1'b0;
      n = 0;
      while (!done && n < 300) begin @(negedge clk); n++; end
      chk(done, "R12", "walk completes", 64'(done), 64'd1);
      r_fault = fault; r_gpf = gpf; r_err = err_code; r_pa = pa;
      r_pw = perm_w; r_px = perm_x; r_pu = perm_u;
      for (int h = 0; h < hold; h++) @(negedge clk);
      if (hold > 0) begin
         chk(done && !busy && pa == r_pa, "R12", "result held", 64'(pa), 64'(r_pa));
      end
      res_ack = 1'b1; @(negedge clk); res_ack = 1'b0;
   endtask

   task automatic tables_long(input logic [63:0] fl);
      mem.delete();
      mem[40'h1008] = 64'h2000 | fl;
      mem[40'h2010] = 64'h3000 | fl;
      mem[40'h3018] = 64'h4000 | fl;
   endtask

   initial begin
      while (cyc < 150000) begin @(posedge clk); cyc++; end
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] pte, exp_mem;
      logic [4:0] code;
      logic ef, epw;
      int r0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req, "R13", "reset outputs", {busy, done, mem_req}, 0);
      rst_n = 1'b1;

      // sweep of final-entry flags, access kind, privilege, wp, nxe (R6 R7 R8 R10 R5)
      for (int a = 0; a < 3; a++)
      for (int u = 0; u < 2; u++)
      for (int w = 0; w < 2; w++)
      for (int x = 0; x < 2; x++)
      for (int f = 0; f < 32; f++) begin
         tables_long(64'h27);
         pte = PG | 64'h1 | (64'(f & 1) << 2) | (64'((f >> 1) & 1) << 1) |
               (64'((f >> 2) & 1) << 63) | (64'((f >> 3) & 1) << 6) | (64'((f >> 4) & 1) << 5);
         mem[40'h4020] = pte;
         wp = w[0]; nxe = x[0];
         code = 5'((a == 1) ? 2 : 0) | 5'(u ? 4 : 0) | 5'((a == 2 && x == 1) ? 16 : 0);
         ef = 1'b1;
         if (pte[63] && !nxe) code = code | 5'd9;
         else if ((a == 2 && pte[63]) || (u == 1 && !pte[2]) ||
                  (a == 1 && !pte[1] && (u == 1 || w == 1))) code = code | 5'd1;
         else ef = 1'b0;
         epw = (pte[6] || a == 1) && (pte[1] || (u == 0 && w == 0));
         exp_mem = ef ? pte : (pte | 64'h20 | ((a == 1) ? 64'h40 : 64'h0));
         walk(VA_L, a[1:0], u[0], 0);
         chk(r_fault == ef && !r_gpf, "R6", "fault", 64'(r_fault), 64'(ef));
         if (ef) chk(r_err == code, "R7", "err_code", 64'(r_err), 64'(code));
         else begin
            chk(r_pa == 40'h12345abc, "R2", "pa", 64'(r_pa), 64'h12345abc);
            chk(r_pw == epw && r_px == !pte[63] && r_pu == pte[2], "R10", "perms",
                {r_pw, r_px, r_pu}, {epw, !pte[63], pte[2]});
         end
         chk(rd(40'h4020) == exp_mem, "R8", "final entry", rd(40'h4020), exp_mem);
      end
      wp = 0; nxe = 0;

      // R1: non-canonical, then canonical upper half
      tables_long(64'h27);
      r0 = n_req;
      walk(64'h0000_8000_0000_0000, 2'd0, 1'b0, 0);
      chk(r_gpf && !r_fault && r_err == 0, "R1", "gpf", {r_gpf, r_fault, 59'(r_err)}, 64'h2 << 62);
      chk(n_req == r0, "R1", "no memory access", 64'(n_req - r0), 0);
      walk(64'hFFFF_8000_0000_0000, 2'd0, 1'b0, 0);
      chk(!r_gpf && r_fault && r_err == 0, "R1", "canonical walks on", {r_gpf, r_fault}, 64'h1);

      // R8 R2: accessed write-back on upper levels
      tables_long(64'h07);
      mem[40'h4020] = PG | 64'h07;
      walk(VA_L, 2'd0, 1'b0, 0);
      chk(!r_fault && r_pa == 40'h12345abc, "R2", "pa upper A clear", 64'(r_pa), 64'h12345abc);
      chk(rd(40'h1008) == 64'h2027 && rd(40'h2010) == 64'h3027 && rd(40'h3018) == 64'h4027,
          "R8", "upper accessed set", rd(40'h3018), 64'h4027);
      chk(rd(40'h4020) == (PG | 64'h27), "R8", "read sets A only", rd(40'h4020), PG | 64'h27);

      // R4: not present at directory
      tables_long(64'h27);
      mem[40'h3018] = 64'h0;
      walk(VA_L, 2'd1, 1'b1, 0);
      chk(r_fault && r_err == 5'h06, "R4", "not present code", 64'(r_err), 64'h06);

      // R5: no-execute set at upper level with nxe off; then fetch with nxe on
      tables_long(64'h27);
      mem[40'h2010] = 64'h3027 | (64'd1 << 63);
      mem[40'h4020] = PG | 64'h67;
      walk(VA_L, 2'd0, 1'b0, 0);
      chk(r_fault && r_err == 5'h09, "R5", "reserved code", 64'(r_err), 64'h09);
      nxe = 1;
      walk(VA_L, 2'd2, 1'b0, 0);
      chk(r_fault && r_err == 5'h11, "R6", "fetch no-exec code", 64'(r_err), 64'h11);
      nxe = 0;

      // R9: 2 MiB page with write
      tables_long(64'h27);
      mem[40'h3018] = 64'h40_0087;
      walk(VA_L, 2'd1, 1'b0, 0);
      chk(!r_fault && r_pa == 40'h404abc, "R9", "large page pa", 64'(r_pa), 64'h404abc);
      chk(rd(40'h3018) == 64'h40_00e7, "R9", "large entry A/D", rd(40'h3018), 64'h4000e7);
      chk(r_pw, "R10", "dirty large page writable", 64'(r_pw), 1);

      // R3: three-level walk, first entry gives full rights and is not written
      mem.delete();
      lma = 0; cr3 = 40'h503f;
      mem[40'h5030] = 64'h6001;
      mem[40'h6018] = 64'h7027;
      mem[40'h7020] = PG | 64'h67;
      walk(64'h0000_0000_8060_4abc, 2'd1, 1'b1, 0);
      chk(!r_fault && r_pa == 40'h12345abc, "R3", "three-level pa", 64'(r_pa), 64'h12345abc);
      chk(rd(40'h5030) == 64'h6001, "R3", "first entry untouched", rd(40'h5030), 64'h6001);
      lma = 1; cr3 = 40'h1000;

      // R11: A20 mask and ignored high entry bits; R12: result hold
      tables_long(64'h27);
      mem[40'h4020] = PG | 64'h67 | (64'd1 << 50);
      a20_mask = ~(40'd1 << 20);
      walk(VA_L, 2'd0, 1'b0, 3);
      chk(!r_fault && r_pa == 40'h12245abc, "R11", "a20 masked pa", 64'(r_pa), 64'h12245abc);
      a20_mask = '1;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule